// File: doc/BRIEF.md
# Complementary PWM Generator with Per-Line Dead Time

This block is a center-aligned PWM engine. A 16-bit counter runs up from zero to a period value and back down to zero. Two compare channels act on a raw PWM level: a compare-0 hit sets it and a compare-1 hit clears it. Each compare channel has its own enable bit for the up-counting direction and for the down-counting direction. Two output lines are derived from the raw level: a true line and a complementary line. Each line has its own dead-time delay on its turn-on edge and its own five-way output-source selector.

The period, both compare values and the two selectors are written into buffer registers. They become active only at a count-zero point that follows a switch event. Several counters that share one switch event therefore change their settings at the same turnaround. The dead times and the direction enables take effect as soon as they are written. A simple write port loads all settings. The outputs are the two line levels, an output enable for each line (low means high impedance) and one match pulse for each compare channel.

Top module: `cpwm_dual_line`

## Requirements
- R1: After a synchronous reset both lines are driven low with their output enables high. Both match pulses are low. Every buffer and active setting is zero, so the lines stay low until a switch event loads new selectors.
- R2: The counter steps 0,1,…,P,P-1,…,1,0,1,… where P is the active period. One full cycle takes 2·P clocks, so a compare value hit in one direction only repeats every 2·P clocks.
- R3: A match output is high for the single clock after the counter equals that channel's active compare value, provided the enable for the current direction is set. The enable register (address 5) uses bit 0 for compare-0 up, bit 1 for compare-0 down, bit 2 for compare-1 up and bit 3 for compare-1 down.
- R4: When a direction is disabled, a compare equality in that direction gives no match pulse and leaves the raw PWM level unchanged.
- R5: A compare-0 hit sets the raw PWM level and a compare-1 hit clears it. If both hit in the same clock, the clear wins.
- R6: The true line follows the raw level. Its turn-on is delayed by the dead time at address 3, in clocks. Its turn-off is immediate.
- R7: The complementary line follows the inverted raw level. Its turn-on is delayed by the independent dead time at address 4. Its turn-off is immediate.
- R8: A dead time of 0 adds no delay. If the level being delayed drops before its dead time expires, the count starts again from zero, so a pulse shorter than the dead time never reaches the line.
- R9: Selector codes are 0 = low, 1 = high, 2 = dead-timed PWM, 3 = inverted dead-timed PWM, and 4 to 7 = high impedance (enable low, level low). The selector buffer is at address 6: bits [2:0] for the true line, bits [5:3] for the complementary line.
- R10: The period (address 0), compare-0 (address 1), compare-1 (address 2) and selector values go to buffers first. They are copied to the active settings only at the first count-zero clock at or after a switch event. Writing a buffer alone changes nothing at the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| switch_evt | input | 1 | Request to load the buffered settings at the next count-zero point |
| line_t_o | output | 1 | True line level |
| line_t_oe | output | 1 | True line output enable (0 = high impedance) |
| line_c_o | output | 1 | Complementary line level |
| line_c_oe | output | 1 | Complementary line output enable (0 = high impedance) |
| cc0_hit_o | output | 1 | Compare-0 match pulse |
| cc1_hit_o | output | 1 | Compare-1 match pulse |

## Verification
A match pulse appears one clock after the counter cycle that holds the compare value. A line reacts two clocks after that cycle, plus its dead time on a turn-on edge. A selector copied at a count-zero clock reaches the lines one clock later. The bench's reference model advances its own counter, raw level, dead-time counts and buffers at each rising edge, using the same register depth. It compares all six outputs at every falling edge. The directed checks measure gaps and pulse counts over windows of whole PWM periods, so the phase at which a window starts cannot change the expected value.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int ADDR_W  = 3;
  localparam int SEL_W   = 3;
  localparam int N_LINES = 2;
  localparam int N_CMP   = 2;

  localparam logic [ADDR_W-1:0] REG_PERIOD   = 3'd0;
  localparam logic [ADDR_W-1:0] REG_CMP0     = 3'd1;
  localparam logic [ADDR_W-1:0] REG_CMP1     = 3'd2;
  localparam logic [ADDR_W-1:0] REG_DT_TRUE  = 3'd3;
  localparam logic [ADDR_W-1:0] REG_DT_COMP  = 3'd4;
  localparam logic [ADDR_W-1:0] REG_GATE     = 3'd5;
  localparam logic [ADDR_W-1:0] REG_LINE_SEL = 3'd6;

  typedef enum logic [SEL_W-1:0] {
    SEL_LOW  = 3'd0,
    SEL_HIGH = 3'd1,
    SEL_PWM  = 3'd2,
    SEL_INV  = 3'd3,
    SEL_HIZ  = 3'd4
  } line_sel_e;

  // bit 0 = compare-0 up ... bit 3 = compare-1 down
  typedef struct packed {
    logic cc1_dn;
    logic cc1_up;
    logic cc0_dn;
    logic cc0_up;
  } hit_gate_t;
endpackage

// File: rtl/cpwm_updn_cnt.sv
module cpwm_updn_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] top_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             up_q,
  output logic             at_zero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b0;
    end else if (at_zero) begin
      up_q  <= 1'b1;
      cnt_q <= (top_val == '0) ? '0 : ONE;
    end else if (up_q && (cnt_q < top_val)) begin
      cnt_q <= cnt_q + ONE;
    end else begin
      up_q  <= 1'b0;
      cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/cpwm_cmp_pair.sv
module cpwm_cmp_pair
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [CNT_W-1:0]            cnt,
  input  logic                        up,
  input  logic [N_CMP-1:0][CNT_W-1:0] cmp,
  input  logic [2*N_CMP-1:0]          gate,
  output logic [N_CMP-1:0]            hit_q,
  output logic                        raw_q
);
  logic [N_CMP-1:0] hit;

  for (genvar i = 0; i < N_CMP; i++) begin : g_ch
    logic allow;
    assign allow  = up ? gate[2*i] : gate[2*i+1];
    assign hit[i] = allow && (cnt == cmp[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= '0;
      raw_q <= 1'b0;
    end else begin
      hit_q <= hit;
      if (hit[1])      raw_q <= 1'b0;
      else if (hit[0]) raw_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int DT_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lvl_in,
  input  logic [DT_W-1:0] dt,
  output logic            lvl_out
);
  localparam logic [DT_W-1:0] ONE = DT_W'(1);

  logic [DT_W-1:0] run_q;
  logic            armed_q;
  logic            expire;

  assign expire  = ({1'b0, run_q} + {1'b0, ONE}) >= {1'b0, dt};
  assign lvl_out = lvl_in & ((dt == '0) | armed_q);

  always_ff @(posedge clk) begin
    if (rst || !lvl_in) begin
      run_q   <= '0;
      armed_q <= 1'b0;
    end else if (!armed_q) begin
      if (expire) armed_q <= 1'b1;
      else        run_q   <= run_q + ONE;
    end
  end
endmodule

// File: rtl/cpwm_line_mux.sv
module cpwm_line_mux
  import cpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             pwm,
  output logic             line_q,
  output logic             oe_q
);
  logic lvl, drv;

  always_comb begin
    lvl = 1'b0;
    drv = 1'b1;
    case (sel)
      SEL_LOW:  lvl = 1'b0;
      SEL_HIGH: lvl = 1'b1;
      SEL_PWM:  lvl = pwm;
      SEL_INV:  lvl = ~pwm;
      default:  drv = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
      oe_q   <= 1'b1;
    end else begin
      line_q <= lvl;
      oe_q   <= drv;
    end
  end
endmodule

// File: rtl/cpwm_dual_line.sv
module cpwm_dual_line
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              switch_evt,
  output logic              line_t_o,
  output logic              line_t_oe,
  output logic              line_c_o,
  output logic              line_c_oe,
  output logic              cc0_hit_o,
  output logic              cc1_hit_o
);
  logic [CNT_W-1:0]                per_buf, per_act, top_val;
  logic [N_CMP-1:0][CNT_W-1:0]     cmp_buf, cmp_act;
  logic [N_LINES-1:0][SEL_W-1:0]   sel_buf, sel_act;
  logic [N_LINES-1:0][DT_W-1:0]    dt_q;
  hit_gate_t                       gate_q;
  logic                            pend_q, reload;
  logic [CNT_W-1:0]                cnt_q;
  logic                            up_q, at_zero, raw_q;
  logic [N_CMP-1:0]                hit_q;
  logic [N_LINES-1:0]              line_q, oe_q;

  assign reload  = at_zero & (pend_q | switch_evt);
  assign top_val = reload ? per_buf : per_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_buf <= '0;
      per_act <= '0;
      cmp_buf <= '0;
      cmp_act <= '0;
      sel_buf <= '0;
      sel_act <= '0;
      dt_q    <= '0;
      gate_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          REG_PERIOD:   per_buf    <= wr_data;
          REG_CMP0:     cmp_buf[0] <= wr_data;
          REG_CMP1:     cmp_buf[1] <= wr_data;
          REG_DT_TRUE:  dt_q[0]    <= wr_data[DT_W-1:0];
          REG_DT_COMP:  dt_q[1]    <= wr_data[DT_W-1:0];
          REG_GATE:     gate_q     <= hit_gate_t'(wr_data[3:0]);
          REG_LINE_SEL: begin
            sel_buf[0] <= wr_data[SEL_W-1:0];
            sel_buf[1] <= wr_data[2*SEL_W-1:SEL_W];
          end
          default: ;
        endcase
      end
      if (reload) begin
        per_act <= per_buf;
        cmp_act <= cmp_buf;
        sel_act <= sel_buf;
        pend_q  <= 1'b0;
      end else if (switch_evt) begin
        pend_q  <= 1'b1;
      end
    end
  end

  cpwm_updn_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .top_val (top_val),
    .cnt_q   (cnt_q),
    .up_q    (up_q),
    .at_zero (at_zero)
  );

  cpwm_cmp_pair #(.CNT_W(CNT_W)) u_cmp (
    .clk   (clk),
    .rst   (rst),
    .cnt   (cnt_q),
    .up    (up_q),
    .cmp   (cmp_act),
    .gate  (gate_q),
    .hit_q (hit_q),
    .raw_q (raw_q)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic src, pwm;
    if (g == 0) begin : g_true
      assign src = raw_q;
    end else begin : g_comp
      assign src = ~raw_q;
    end

    cpwm_deadband #(.DT_W(DT_W)) u_db (
      .clk     (clk),
      .rst     (rst),
      .lvl_in  (src),
      .dt      (dt_q[g]),
      .lvl_out (pwm)
    );

    cpwm_line_mux u_mux (
      .clk    (clk),
      .rst    (rst),
      .sel    (sel_act[g]),
      .pwm    (pwm),
      .line_q (line_q[g]),
      .oe_q   (oe_q[g])
    );
  end

  assign line_t_o  = line_q[0];
  assign line_t_oe = oe_q[0];
  assign line_c_o  = line_q[1];
  assign line_c_oe = oe_q[1];
  assign cc0_hit_o = hit_q[0];
  assign cc1_hit_o = hit_q[1];
endmodule

// File: rtl/cpwm_dual_line_chk.sv
module cpwm_dual_line_chk
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per_act,
  input logic             up,
  input logic [CNT_W-1:0] cmp0,
  input logic [CNT_W-1:0] cmp1,
  input logic [3:0]       gate,
  input logic [SEL_W-1:0] sel_t,
  input logic [SEL_W-1:0] sel_c,
  input logic             line_t,
  input logic             oe_t,
  input logic             line_c,
  input logic             oe_c,
  input logic             hit0,
  input logic             hit1
);
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= per_act);

  p_hit0_up_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt == cmp0 && up && gate[0]) |=> hit0);

  p_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt == cmp1 && !(up ? gate[2] : gate[3])) |=> !hit1);

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
    (sel_t == SEL_PWM && sel_c == SEL_PWM) |=> !(line_t && line_c));

  p_hiz_true_r9: assert property (@(posedge clk) disable iff (rst)
    !oe_t |-> !line_t);

  p_hiz_comp_r9: assert property (@(posedge clk) disable iff (rst)
    !oe_c |-> !line_c);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> ($stable(per_act) && $stable(sel_t) && $stable(sel_c)));
endmodule

bind cpwm_dual_line cpwm_dual_line_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cnt     (cnt_q),
  .per_act (per_act),
  .up      (up_q),
  .cmp0    (cmp_act[0]),
  .cmp1    (cmp_act[1]),
  .gate    (gate_q),
  .sel_t   (sel_act[0]),
  .sel_c   (sel_act[1]),
  .line_t  (line_t_o),
  .oe_t    (line_t_oe),
  .line_c  (line_c_o),
  .oe_c    (line_c_oe),
  .hit0    (cc0_hit_o),
  .hit1    (cc1_hit_o)
);

// File: tb/sim_cpwm_dual_line.sv
`timescale 1ns/1ps
module sim_cpwm_dual_line;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        switch_evt = 1'b0;
  logic        line_t_o, line_t_oe, line_c_o, line_c_oe, cc0_hit_o, cc1_hit_o;

  int    tests = 0, fails = 0;
  bit    done = 0, cmp_on = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  cpwm_dual_line u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .switch_evt(switch_evt), .line_t_o(line_t_o), .line_t_oe(line_t_oe),
    .line_c_o(line_c_o), .line_c_oe(line_c_oe), .cc0_hit_o(cc0_hit_o), .cc1_hit_o(cc1_hit_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cnt, m_up, m_per_a, m_per_b, m_c0a, m_c0b, m_c1a, m_c1b;
  int m_sta, m_stb, m_sca, m_scb, m_dtt, m_dtc, m_en, m_pend, m_raw;
  int m_runt, m_armt, m_runc, m_armc;
  int m_lt, m_ot, m_lc, m_oc, m_h0, m_h1;

  function automatic int pick(input int sel, input int s);
    case (sel)
      0: return 0;
      1: return 1;
      2: return s;
      3: return (s != 0) ? 0 : 1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int h0, h1, nraw, ts, cs, rl, pe;
    if (rst) begin
      m_cnt = 0; m_up = 0; m_per_a = 0; m_per_b = 0; m_c0a = 0; m_c0b = 0;
      m_c1a = 0; m_c1b = 0; m_sta = 0; m_stb = 0; m_sca = 0; m_scb = 0;
      m_dtt = 0; m_dtc = 0; m_en = 0; m_pend = 0; m_raw = 0;
      m_runt = 0; m_armt = 0; m_runc = 0; m_armc = 0;
      m_lt = 0; m_ot = 1; m_lc = 0; m_oc = 1; m_h0 = 0; m_h1 = 0;
    end else begin
      h0 = (m_cnt == m_c0a) && (((m_up != 0) ? m_en : (m_en >> 1)) & 1) != 0;
      h1 = (m_cnt == m_c1a) && (((m_up != 0) ? (m_en >> 2) : (m_en >> 3)) & 1) != 0;
      nraw = h1 ? 0 : (h0 ? 1 : m_raw);
      ts = (m_raw != 0) && (m_dtt == 0 || m_armt != 0);
      cs = (m_raw == 0) && (m_dtc == 0 || m_armc != 0);
      m_lt = pick(m_sta, ts); m_ot = (m_sta <= 3);
      m_lc = pick(m_sca, cs); m_oc = (m_sca <= 3);
      if (m_raw == 0) begin m_runt = 0; m_armt = 0; end
      else if (m_armt == 0) begin if (m_runt + 1 >= m_dtt) m_armt = 1; else m_runt++; end
      if (m_raw != 0) begin m_runc = 0; m_armc = 0; end
      else if (m_armc == 0) begin if (m_runc + 1 >= m_dtc) m_armc = 1; else m_runc++; end
      rl = (m_cnt == 0) && (m_pend != 0 || switch_evt);
      pe = rl ? m_per_b : m_per_a;
      if (m_cnt == 0) begin m_up = 1; m_cnt = (pe == 0) ? 0 : 1; end
      else if (m_up != 0 && m_cnt < pe) m_cnt++;
      else begin m_up = 0; m_cnt--; end
      if (rl) begin
        m_per_a = m_per_b; m_c0a = m_c0b; m_c1a = m_c1b; m_sta = m_stb; m_sca = m_scb; m_pend = 0;
      end else if (switch_evt) m_pend = 1;
      m_h0 = h0; m_h1 = h1; m_raw = nraw;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_per_b = wr_data;
          3'd1: m_c0b = wr_data;
          3'd2: m_c1b = wr_data;
          3'd3: m_dtt = wr_data;
          3'd4: m_dtc = wr_data;
          3'd5: m_en = wr_data & 15;
          3'd6: begin m_stb = wr_data & 7; m_scb = (wr_data >> 3) & 7; end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on)
      chk(cur_req, "outputs {lt,ot,lc,oc,h0,h1}",
          {line_t_o, line_t_oe, line_c_o, line_c_oe, cc0_hit_o, cc1_hit_o},
          {m_lt[0], m_ot[0], m_lc[0], m_oc[0], m_h0[0], m_h1[0]});
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic sw();
    @(negedge clk); switch_evt = 1'b1;
    @(negedge clk); switch_evt = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // which: 0 true high, 1 comp high, 2 hit0, 3 hit1, 4 comp low
  task automatic count(input int n, input int which, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (which)
        0: c += int'(line_t_o);
        1: c += int'(line_c_o);
        2: c += int'(cc0_hit_o);
        3: c += int'(cc1_hit_o);
        default: c += int'(!line_c_o);
      endcase
    end
  endtask

  task automatic gap(input bit from_c, output int g);
    bit pf, pr, f, r;
    int start = -1;
    g = -1;
    pf = from_c ? line_c_o : line_t_o;
    pr = from_c ? line_t_o : line_c_o;
    for (int i = 0; i < 200 && g < 0; i++) begin
      @(negedge clk);
      f = from_c ? line_c_o : line_t_o;
      r = from_c ? line_t_o : line_c_o;
      if (pf && !f) start = i;
      if (start >= 0 && !pr && r) g = i - start;
      pf = f; pr = r;
    end
  endtask

  task automatic hit_interval(output int iv);
    int first = -1;
    bit prev = cc0_hit_o;
    iv = -1;
    for (int i = 0; i < 200 && iv < 0; i++) begin
      @(negedge clk);
      if (!prev && cc0_hit_o) begin
        if (first < 0) first = i; else iv = i - first;
      end
      prev = cc0_hit_o;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset outputs", {line_t_o, line_t_oe, line_c_o, line_c_oe, cc0_hit_o, cc1_hit_o}, 6'b010100);
    rst = 1'b0; cmp_on = 1;
    count(20, 0, v); chk("R1", "true line high count after reset", v, 0);

    // buffered setup, no switch yet
    cur_req = "R10";
    wr(3'd0, 16'd20); wr(3'd1, 16'd5); wr(3'd2, 16'd15);
    wr(3'd5, 16'b1001); wr(3'd3, 16'd5); wr(3'd4, 16'd9); wr(3'd6, 16'h12);
    count(40, 0, v); chk("R10", "true line before switch", v, 0);
    count(40, 1, v); chk("R10", "comp line before switch", v, 0);

    cur_req = "R6";
    sw(); idle(80);
    gap(1'b1, v); chk("R6", "comp fall to true rise", v, 5);
    cur_req = "R7";
    gap(1'b0, v); chk("R7", "true fall to comp rise", v, 9);
    cur_req = "R2";
    hit_interval(v); chk("R2", "compare-0 up-only repeat", v, 40);

    // direction gating
    cur_req = "R4";
    wr(3'd5, 16'b0011); idle(45);
    count(80, 2, v); chk("R3", "compare-0 pulses both directions", v, 4);
    count(80, 3, v); chk("R4", "compare-1 pulses with both directions off", v, 0);
    chk("R4", "true line held high", int'(line_t_o), 1);
    chk("R4", "comp line held low", int'(line_c_o), 0);

    // zero dead time
    cur_req = "R8";
    wr(3'd5, 16'b1001); wr(3'd3, 16'd0); wr(3'd4, 16'd0); idle(45);
    gap(1'b1, v); chk("R8", "zero dead time comp fall to true rise", v, 0);
    gap(1'b0, v); chk("R8", "zero dead time true fall to comp rise", v, 0);

    // short pulse shorter than dead time
    wr(3'd1, 16'd5); wr(3'd2, 16'd7); wr(3'd5, 16'b0101); wr(3'd3, 16'd4);
    sw(); idle(50);
    count(80, 0, v); chk("R8", "short pulse never reaches true line", v, 0);
    count(80, 4, v); chk("R8", "comp line low cycles over two periods", v, 4);

    // simultaneous hits: clear wins
    cur_req = "R5";
    wr(3'd3, 16'd0); wr(3'd1, 16'd8); wr(3'd2, 16'd8); wr(3'd5, 16'b1111);
    sw(); idle(50);
    count(80, 0, v); chk("R5", "tie keeps raw low", v, 0);
    count(80, 2, v); chk("R5", "compare-0 still pulses on tie", v, 4);

    // selector codes
    cur_req = "R9";
    wr(3'd6, 16'h21); sw(); idle(45);
    chk("R9", "high/hiz outputs", {line_t_o, line_t_oe, line_c_o, line_c_oe}, 4'b1100);
    wr(3'd6, 16'h3B); sw(); idle(45);
    chk("R9", "inverted/code7 outputs", {line_t_o, line_t_oe, line_c_o, line_c_oe}, 4'b1100);
    wr(3'd6, 16'h08); sw(); idle(45);
    chk("R9", "low/high outputs", {line_t_o, line_t_oe, line_c_o, line_c_oe}, 4'b0111);

    // reload only at count zero
    cur_req = "R10";
    wr(3'd6, 16'h09); idle(60);
    chk("R10", "buffer write alone", {line_t_o, line_c_o}, 2'b01);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (m_cnt == 10 && m_up == 1) break;
    end
    switch_evt = 1'b1;
    @(negedge clk); switch_evt = 1'b0;
    idle(5);
    chk("R10", "switch mid-count not yet applied", {line_t_o, line_c_o}, 2'b01);
    idle(40);
    chk("R10", "switch applied after zero point", {line_t_o, line_c_o}, 2'b11);

    done = 1;
    cmp_on = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule